// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This unit works out the output frequency of a fractional-N PLL from its reference frequency and its divider settings. The settings are a feedback multiplier `m`, a pre-divider `p`, a power-of-two post-divider exponent `s` and a signed 16-bit fractional correction `k`. The rate is `(m*65536 + k) * fin / (p * 65536 * 2^s)`, truncated to an integer. A flag marks a PLL that has no fractional part; for such a PLL `k` is treated as zero whatever value is on the port.

A request is issued with a one-cycle `start_i` while the unit is idle. The numerator and denominator are formed at once. A restoring long divider then produces one quotient bit per clock. The result appears with a one-cycle `valid_o` pulse. Settings that fall outside the legal ranges are rejected right away: the error flag is set and the rate is zero. Software can use the unit to read back the current PLL rate, or to test a candidate setting before programming it.

Top module: `frac_pll_rate`

## Requirements
- R1: For legal settings, `rate_o` equals floor(((m*65536 + k) * fin) / (p * 2^(16+s))), computed with a NUM_W-bit intermediate product.
- R2: `k_i` is read as a two's-complement 16-bit value from -32768 to 32767, so a negative `k_i` gives a lower rate than `k_i` = 0.
- R3: While `int_only_i` is 1, the result is the one for `k` = 0, whatever value is on `k_i`.
- R4: A pre-divider of `p_i` = 0 (legal range 1 to 63) makes the result have `err_o` = 1 and `rate_o` = 0.
- R5: A multiplier `m_i` below 64 (legal range 64 to 1023) makes the result have `err_o` = 1 and `rate_o` = 0.
- R6: A post-divider exponent `s_i` of 7 (legal range 0 to 6) makes the result have `err_o` = 1 and `rate_o` = 0.
- R7: `valid_o` is a one-cycle pulse. For rejected settings it is high in the cycle after the accepting edge. For legal settings it is high after NUM_W further clock edges, and `busy_o` is high in between.
- R8: A `start_i` raised while `busy_o` is 1 is ignored: the running result and its timing are unchanged.
- R9: After reset, `valid_o`, `busy_o`, `err_o` and `rate_o` are all zero.
- R10: `rate_o` and `err_o` change only in a cycle where `valid_o` is 1, and they hold their values until the next result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only while idle |
| int_only_i | input | 1 | 1 forces the fractional term to zero |
| fin_i | input | FIN_W | Reference frequency in Hz |
| m_i | input | 10 | Feedback multiplier |
| p_i | input | 6 | Pre-divider |
| s_i | input | 3 | Post-divider exponent |
| k_i | input | 16 | Signed fractional correction |
| busy_o | output | 1 | Divider running |
| valid_o | output | 1 | Result pulse |
| err_o | output | 1 | Last result came from illegal settings |
| rate_o | output | NUM_W | Last computed rate in Hz |

## Verification
The hardest case to reach is a request that arrives on the same edge the divider retires its last quotient bit. At that edge `busy_o` is still high, so the request must be dropped, yet the result pulse fires on that very edge. The bench gets there by holding `start_i` high for the whole of a computation and past its end. The reference model then requires that only the first request ran. It also checks the extreme corners: largest multiplier with the most negative `k`, largest pre-divider and post-divider, and the full-scale reference frequency.

// File: rtl/frac_pll_pkg.sv
package frac_pll_pkg;
  localparam int M_W      = 10;
  localparam int P_W      = 6;
  localparam int S_W      = 3;
  localparam int K_W      = 16;
  localparam int FRAC_SH  = 16;
  localparam int M_LO     = 64;
  localparam int M_HI     = 1023;
  localparam int P_LO     = 1;
  localparam int P_HI     = 63;
  localparam int S_HI     = 6;

  typedef struct packed {
    logic [M_W-1:0] mul;
    logic [P_W-1:0] pre;
    logic [S_W-1:0] post;
    logic [K_W-1:0] frac;
  } pll_setting_t;
endpackage

// File: rtl/frac_pll_legal.sv
module frac_pll_legal
  import frac_pll_pkg::*;
(
  input  pll_setting_t set_i,
  output logic         legal_o
);
  logic [31:0] m_w, p_w, s_w;

  always_comb begin
    m_w     = 32'(set_i.mul);
    p_w     = 32'(set_i.pre);
    s_w     = 32'(set_i.post);
    legal_o = (m_w >= 32'(M_LO)) && (m_w <= 32'(M_HI)) &&
              (p_w >= 32'(P_LO)) && (p_w <= 32'(P_HI)) &&
              (s_w <= 32'(S_HI));
  end
endmodule

// File: rtl/frac_pll_operand.sv
module frac_pll_operand
  import frac_pll_pkg::*;
#(
  parameter int FIN_W = 32,
  parameter int NUM_W = 64,
  parameter int DEN_W = 28
) (
  input  logic [FIN_W-1:0] fin_i,
  input  pll_setting_t     set_i,
  input  logic             int_only_i,
  output logic [NUM_W-1:0] num_o,
  output logic [DEN_W-1:0] den_o
);
  localparam int MUL_W  = M_W + FRAC_SH + 1;
  localparam int PROD_W = MUL_W + FIN_W;

  logic [K_W-1:0]    k_eff;
  logic [MUL_W-1:0]  term;
  logic [PROD_W-1:0] prod;

  always_comb begin
    k_eff = int_only_i ? '0 : set_i.frac;
    term  = {1'b0, set_i.mul, {FRAC_SH{1'b0}}} +
            {{(MUL_W-K_W){k_eff[K_W-1]}}, k_eff};
    prod  = PROD_W'(term) * PROD_W'(fin_i);
    num_o = NUM_W'(prod);
    den_o = DEN_W'(set_i.pre) << (FRAC_SH + int'(set_i.post));
  end
endmodule

// File: rtl/frac_pll_divider.sv
module frac_pll_divider #(
  parameter int NUM_W = 64,
  parameter int DEN_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CNT_W = $clog2(NUM_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_W - 1);

  logic [DEN_W-1:0] rem_q, rem_n, den_q, den_n;
  logic [NUM_W-1:0] quo_q, quo_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             busy_q, busy_n;
  logic [DEN_W:0]   trial;
  logic             fits;
  logic             en;

  always_comb begin
    trial  = {rem_q, quo_q[NUM_W-1]};
    fits   = trial >= {1'b0, den_q};
    rem_n  = rem_q;
    quo_n  = quo_q;
    den_n  = den_q;
    cnt_n  = cnt_q;
    busy_n = busy_q;
    en     = 1'b0;
    if (busy_q) begin
      en     = 1'b1;
      rem_n  = fits ? DEN_W'(trial - {1'b0, den_q}) : DEN_W'(trial);
      quo_n  = {quo_q[NUM_W-2:0], fits};
      cnt_n  = cnt_q + 1'b1;
      busy_n = (cnt_q != LAST);
    end else if (load_i) begin
      en     = 1'b1;
      rem_n  = '0;
      quo_n  = num_i;
      den_n  = den_i;
      cnt_n  = '0;
      busy_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (en) begin
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      den_q  <= den_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST);
  assign quo_o  = quo_n;

  // R1: the partial remainder stays below the divisor through every step
  p_rem_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < den_q));

  // R8: the divisor cannot be replaced while a division is running
  p_den_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (!busy_q || $stable(den_q)));

  // R7: each division starts from step zero
  p_start_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> (cnt_q == '0));
endmodule

// File: rtl/frac_pll_rate.sv
module frac_pll_rate
  import frac_pll_pkg::*;
#(
  parameter int FIN_W = 32,
  parameter int NUM_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             int_only_i,
  input  logic [FIN_W-1:0] fin_i,
  input  logic [M_W-1:0]   m_i,
  input  logic [P_W-1:0]   p_i,
  input  logic [S_W-1:0]   s_i,
  input  logic [K_W-1:0]   k_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic             err_o,
  output logic [NUM_W-1:0] rate_o
);
  localparam int DEN_W = P_W + FRAC_SH + S_HI;

  pll_setting_t     set;
  logic             legal, accept, load;
  logic [NUM_W-1:0] num, quo;
  logic [DEN_W-1:0] den;
  logic             div_busy, div_done;

  logic             valid_q, valid_n;
  logic             err_q, err_n;
  logic [NUM_W-1:0] rate_q, rate_n;
  logic             res_en;

  assign set = '{mul: m_i, pre: p_i, post: s_i, frac: k_i};

  frac_pll_legal u_legal (
    .set_i   (set),
    .legal_o (legal)
  );

  frac_pll_operand #(.FIN_W(FIN_W), .NUM_W(NUM_W), .DEN_W(DEN_W)) u_operand (
    .fin_i      (fin_i),
    .set_i      (set),
    .int_only_i (int_only_i),
    .num_o      (num),
    .den_o      (den)
  );

  assign accept = start_i && !div_busy;
  assign load   = accept && legal;

  frac_pll_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .num_i  (num),
    .den_i  (den),
    .busy_o (div_busy),
    .done_o (div_done),
    .quo_o  (quo)
  );

  always_comb begin
    valid_n = 1'b0;
    err_n   = err_q;
    rate_n  = rate_q;
    res_en  = 1'b0;
    if (accept && !legal) begin
      res_en  = 1'b1;
      valid_n = 1'b1;
      err_n   = 1'b1;
      rate_n  = '0;
    end else if (div_done) begin
      res_en  = 1'b1;
      valid_n = 1'b1;
      err_n   = 1'b0;
      rate_n  = quo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      rate_q  <= '0;
    end else begin
      valid_q <= valid_n;
      if (res_en) begin
        err_q  <= err_n;
        rate_q <= rate_n;
      end
    end
  end

  assign busy_o  = div_busy;
  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign rate_o  = rate_q;

  // R4: a rejected setting always reports a zero rate
  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (rate_o == '0));

  // R10: the reported rate moves only together with a result pulse
  p_rate_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rate_o) |-> valid_o);

  // R10: the error flag moves only together with a result pulse
  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(err_o) |-> valid_o);

  // R7: a good result is never reported while the divider still runs
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !err_o) |-> !busy_o);
endmodule

// File: tb/frac_pll_rate_test.sv
module frac_pll_rate_test;
  localparam int FIN_W = 32;
  localparam int NUM_W = 64;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start_i = 1'b0;
  logic             int_only_i = 1'b0;
  logic [FIN_W-1:0] fin_i = '0;
  logic [9:0]       m_i = '0;
  logic [5:0]       p_i = '0;
  logic [2:0]       s_i = '0;
  logic [15:0]      k_i = '0;
  logic             busy_o, valid_o, err_o;
  logic [NUM_W-1:0] rate_o;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string cur_req = "R9";

  frac_pll_rate #(.FIN_W(FIN_W), .NUM_W(NUM_W)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .int_only_i(int_only_i),
    .fin_i(fin_i), .m_i(m_i), .p_i(p_i), .s_i(s_i), .k_i(k_i),
    .busy_o(busy_o), .valid_o(valid_o), .err_o(err_o), .rate_o(rate_o)
  );

  always #4 clk = ~clk;

  function automatic longint unsigned ref_rate(
      logic [31:0] fin, logic [9:0] m, logic [5:0] p, logic [2:0] s,
      logic [15:0] k, logic io);
    longint           kk, term;
    longint unsigned  num, den;
    kk   = io ? 0 : longint'($signed(k));
    term = longint'(m) * 65536 + kk;
    num  = longint'(unsigned'(term)) * longint'(fin);
    den  = longint'(p) << (16 + int'(s));
    return num / den;
  endfunction

  function automatic bit is_legal(logic [9:0] m, logic [5:0] p, logic [2:0] s);
    return (m >= 64) && (p >= 1) && (s <= 6);
  endfunction

  // behavioural reference model
  bit              m_busy = 0, e_valid = 0, e_err = 0;
  int              m_cnt = 0;
  longint unsigned m_res = 0, e_rate = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; e_valid = 0; e_err = 0; e_rate = 0;
    end else begin
      e_valid = 0;
      if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; e_valid = 1; e_err = 0; e_rate = m_res;
        end
      end else if (start_i) begin
        if (!is_legal(m_i, p_i, s_i)) begin
          e_valid = 1; e_err = 1; e_rate = 0;
        end else begin
          m_busy = 1; m_cnt = NUM_W;
          m_res  = ref_rate(fin_i, m_i, p_i, s_i, k_i, int_only_i);
        end
      end
    end
  end

  task automatic chk(string what, longint unsigned act, longint unsigned exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("valid", valid_o, e_valid);
      chk("busy",  busy_o,  m_busy);
      chk("err",   err_o,   e_err);
      chk("rate",  rate_o,  e_rate);
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d expected<150000", cycles);
      finish_run();
    end
  end

  task automatic run(string req, logic [31:0] fin, logic [9:0] m, logic [5:0] p,
                     logic [2:0] s, logic [15:0] k, logic io, bit hold);
    int lat;
    bit legal;
    cur_req = req;
    legal = is_legal(m, p, s);
    @(negedge clk);
    fin_i = fin; m_i = m; p_i = p; s_i = s; k_i = k; int_only_i = io;
    start_i = 1'b1;
    @(posedge clk);
    lat = 0;
    forever begin
      @(negedge clk);
      lat++;
      start_i = hold;
      if (valid_o || lat > 1000) break;
    end
    start_i = 1'b0;
    // R7: latency from accepting edge to the result pulse
    chk("latency R7", lat, legal ? NUM_W + 1 : 1);
    if (legal) chk("result R1", rate_o, ref_rate(fin, m, p, s, k, io));
    else       chk("error R4 R5 R6", err_o, 1);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: outputs idle straight after reset
    chk("reset valid R9", valid_o, 0);
    chk("reset busy R9",  busy_o,  0);
    chk("reset err R9",   err_o,   0);
    chk("reset rate R9",  rate_o,  0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run("R1", 32'd24_000_000, 10'd300, 6'd3, 3'd1, 16'd0, 1'b0, 1'b0);
    chk("R1 value", rate_o, 64'd1_200_000_000);
    run("R1", 32'd24_000_000, 10'd173, 6'd2, 3'd1, 16'd16384, 1'b0, 1'b0);
    run("R2", 32'd24_000_000, 10'd173, 6'd2, 3'd1, 16'(-1234), 1'b0, 1'b0);
    chk("R2 below k0", (rate_o < ref_rate(24_000_000, 173, 2, 1, 0, 0)), 1);
    run("R2", 32'hFFFF_FFFF, 10'd1023, 6'd1, 3'd0, 16'h8000, 1'b0, 1'b0);
    run("R1", 32'hFFFF_FFFF, 10'd1023, 6'd1, 3'd0, 16'h7FFF, 1'b0, 1'b0);
    run("R1", 32'd25_000_000, 10'd64, 6'd63, 3'd6, 16'h7FFF, 1'b0, 1'b0);
    run("R3", 32'd24_000_000, 10'd173, 6'd2, 3'd1, 16'd16384, 1'b1, 1'b0);
    chk("R3 equals k0", rate_o, ref_rate(24_000_000, 173, 2, 1, 0, 0));
    run("R4", 32'd24_000_000, 10'd300, 6'd0, 3'd1, 16'd0, 1'b0, 1'b0);
    chk("R4 rate", rate_o, 0);
    run("R1", 32'd19_200_000, 10'd250, 6'd3, 3'd2, 16'd100, 1'b0, 1'b0);
    run("R5", 32'd24_000_000, 10'd63, 6'd3, 3'd1, 16'd0, 1'b0, 1'b0);
    chk("R5 rate", rate_o, 0);
    run("R6", 32'd24_000_000, 10'd300, 6'd3, 3'd7, 16'd0, 1'b0, 1'b0);
    chk("R6 rate", rate_o, 0);
    // R8: start held high through the run and past its end
    run("R8", 32'd27_000_000, 10'd198, 6'd2, 3'd2, 16'd0, 1'b0, 1'b1);
    // R10: hold values over idle cycles (compared every clock)
    cur_req = "R10";
    repeat (10) @(negedge clk);
    chk("R10 hold", rate_o, ref_rate(27_000_000, 198, 2, 2, 0, 0));
    finish_run();
  end
endmodule